// File: doc/BRIEF.md
# Halt-Mode Power Sequencing Controller

This controller decides what happens when a processor core asks to stop in its deepest low-power state, and it brings the core back. When a halt strobe arrives and the lighter active-halt option is off, the controller does one of two things. If the watchdog is running and its halt-tolerance option is clear, it raises a watchdog reset and the core keeps running. In every other case it enters halt: the oscillator, peripheral-clock and CPU-clock enables all drop, and the interrupt mask is forced open.

While halted, only an external reset or an interrupt line marked as wake-capable can end the halt. A wake first turns the oscillator back on. A settling counter then runs for a fixed number of reference-clock cycles, and only after that do the CPU and peripheral clocks return. In the first running cycle a one-cycle strobe tells the core to fetch the reset vector or to service the interrupt. A status code records which source ended the halt.

Top module: `halt_pwr_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, the controller goes to the running state: osc_en, periph_clk_en and cpu_clk_en are 1; imask_clr, wdg_rst, vec_fetch and irq_service are 0; wake_src is 0.
- R2: A halt request sampled while act_halt_en is 1 has no effect: all clock enables stay 1 and no watchdog reset is raised.
- R3: A halt request sampled with act_halt_en 0, wdg_en 1 and wdg_halt_opt 0 produces a watchdog reset instead of a halt. wdg_rst is 1 for exactly the next cycle, and the clock enables stay 1.
- R4: A halt request sampled with act_halt_en 0 and either wdg_en 0 or wdg_halt_opt 1 enters halt. From the next cycle, osc_en, periph_clk_en and cpu_clk_en are 0 and imask_clr is 1.
- R5: While halted, only the interrupt lines whose bit is set in WAKE_MASK (default 4'b0101, which is lines 0 and 2) end the halt, together with ext_rst. Any other line leaves all outputs unchanged.
- R6: If a wake-capable interrupt is already pending in the cycle the halt is entered, osc_en returns to 1 in the cycle after the first halted cycle.
- R7: After a wake, osc_en is 1 while cpu_clk_en and periph_clk_en stay 0 for exactly SETTLE_CYC (64) cycles. After that, all enables are 1 and imask_clr returns to 0.
- R8: In the first running cycle after the settling delay, exactly one one-cycle strobe is raised: vec_fetch for a reset wake, or irq_service for an interrupt wake.
- R9: When ext_rst and a wake-capable interrupt arrive in the same cycle, the wake is treated as a reset wake.
- R10: wake_src reports 1 after a reset wake and 2 after an interrupt wake. It is set in the first settling cycle, holds its value, and is cleared to 0 on the next halt entry.
- R11: The settling counter restarts from zero on every wake, so each wake in a sequence of wakes takes the full SETTLE_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_req | input | 1 | Halt instruction strobe |
| act_halt_en | input | 1 | Active-halt selected; a halt request is ignored when 1 |
| wdg_en | input | 1 | Watchdog is running |
| wdg_halt_opt | input | 1 | Watchdog halt option; 0 turns a halt into a watchdog reset |
| irq_req | input | NIRQ | Interrupt request lines |
| ext_rst | input | 1 | External reset request; wakes the controller from halt |
| osc_en | output | 1 | Main oscillator enable |
| periph_clk_en | output | 1 | Gated peripheral clock enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| imask_clr | output | 1 | Forces the global interrupt mask open |
| wdg_rst | output | 1 | One-cycle watchdog reset |
| vec_fetch | output | 1 | One-cycle strobe: fetch the reset vector |
| irq_service | output | 1 | One-cycle strobe: service the interrupt |
| wake_src | output | 2 | Last wake source: 0 none, 1 reset, 2 interrupt |

## Verification
Every result is registered once, so each result follows its stimulus by a fixed number of cycles:
- The clock-enable drop, the watchdog pulse and the ignore case show one cycle after the halt request edge.
- Wake detection shows one cycle after the wake input is sampled in halt.
- The resume strobes come SETTLE_CYC cycles after wake detection.

The bench drives inputs on falling edges and samples on the next falling edge. It measures the settling window by counting falling edges while osc_en is 1 and cpu_clk_en is 0. It sweeps every interrupt pattern against both values of ext_rst and compares the outcome with arithmetic on WAKE_MASK.

// File: rtl/halt_pwr_pkg.sv
// Shared types for the halt power sequencing controller.
// Assumes a two-bit state and a two-bit wake source code.
package halt_pwr_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_HALT   = 2'd1,
        ST_SETTLE = 2'd2
    } hp_state_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_RST  = 2'd1,
        SRC_IRQ  = 2'd2
    } wake_src_e;
endpackage

// File: rtl/halt_wake_arb.sv
// Wake arbiter: filters the interrupt lines through the wake-capable mask
// and gives the external reset priority over an interrupt wake.
// Assumes its inputs are already synchronous to the reference clock.
module halt_wake_arb #(
    parameter int           NIRQ      = 4,
    parameter logic [NIRQ-1:0] WAKE_MASK = 4'b0101
) (
    input  logic [NIRQ-1:0] irq_req,
    input  logic            ext_rst,
    output logic            wake,
    output logic            wake_is_rst
);
    logic [NIRQ-1:0] masked;

    // Keep only the lines allowed to end a halt
    for (genvar i = 0; i < NIRQ; i++) begin : g_mask
        assign masked[i] = WAKE_MASK[i] & irq_req[i];
    end

    // Combine the wake sources; a reset takes precedence
    always_comb begin
        wake        = ext_rst | (|masked);
        wake_is_rst = ext_rst;
    end
endmodule

// File: rtl/halt_settle_cnt.sv
// Oscillator settling counter: clears on a wake, counts while enabled,
// and flags the last cycle of a window of SETTLE_CYC cycles.
// Assumes SETTLE_CYC >= 2 and that the reference clock runs during settling.
module halt_settle_cnt #(
    parameter int SETTLE_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic done
);
    localparam int W = (SETTLE_CYC > 2) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [W-1:0] LAST = W'(SETTLE_CYC - 1);

    logic [W-1:0] cnt;

    // Count the settling cycles, restarting on every wake
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (en)  cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    // Flag the final cycle of the window
    always_comb done = en && (cnt == LAST);

    // R11
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && !done) |=> (cnt == $past(cnt) + 1'b1));

    // R11
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
endmodule

// File: rtl/halt_pwr_ctrl.sv
// Halt power sequencing controller (top).
// Decides whether a halt request becomes a halt, a watchdog reset or nothing.
// While halted it keeps the clocks off and waits for an allowed wake source.
// On a wake it runs the oscillator settling delay, then restores the clocks
// and raises a one-cycle resume strobe.
// Assumes all inputs are synchronous to clk, and clk runs throughout.
module halt_pwr_ctrl
    import halt_pwr_pkg::*;
#(
    parameter int              NIRQ       = 4,
    parameter logic [NIRQ-1:0] WAKE_MASK  = 4'b0101,
    parameter int              SETTLE_CYC = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            halt_req,
    input  logic            act_halt_en,
    input  logic            wdg_en,
    input  logic            wdg_halt_opt,
    input  logic [NIRQ-1:0] irq_req,
    input  logic            ext_rst,
    output logic            osc_en,
    output logic            periph_clk_en,
    output logic            cpu_clk_en,
    output logic            imask_clr,
    output logic            wdg_rst,
    output logic            vec_fetch,
    output logic            irq_service,
    output logic [1:0]      wake_src
);
    hp_state_e st, st_nxt;
    logic      wake, wake_is_rst, settle_done;
    logic      req_ok, wdg_block, enter, wdg_fire, wake_now;
    logic      src_rst_q;

    halt_wake_arb #(.NIRQ(NIRQ), .WAKE_MASK(WAKE_MASK)) arb_i (
        .irq_req     (irq_req),
        .ext_rst     (ext_rst),
        .wake        (wake),
        .wake_is_rst (wake_is_rst)
    );

    halt_settle_cnt #(.SETTLE_CYC(SETTLE_CYC)) cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wake_now),
        .en    (st == ST_SETTLE),
        .done  (settle_done)
    );

    // Classify the halt request and detect a wake while halted
    always_comb begin
        req_ok    = (st == ST_RUN) && halt_req && !act_halt_en;
        wdg_block = wdg_en && !wdg_halt_opt;
        enter     = req_ok && !wdg_block;
        wdg_fire  = req_ok && wdg_block;
        wake_now  = (st == ST_HALT) && wake;
    end

    // Next-state selection
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_RUN:    if (enter)       st_nxt = ST_HALT;
            ST_HALT:   if (wake)        st_nxt = ST_SETTLE;
            ST_SETTLE: if (settle_done) st_nxt = ST_RUN;
            default:                    st_nxt = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_RUN;
        else        st <= st_nxt;
    end

    // Latch the wake source and produce the watchdog and resume pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_rst_q   <= 1'b0;
            wake_src    <= SRC_NONE;
            wdg_rst     <= 1'b0;
            vec_fetch   <= 1'b0;
            irq_service <= 1'b0;
        end else begin
            wdg_rst     <= wdg_fire;
            vec_fetch   <= settle_done && src_rst_q;
            irq_service <= settle_done && !src_rst_q;
            if (enter) begin
                wake_src <= SRC_NONE;
            end else if (wake_now) begin
                src_rst_q <= wake_is_rst;
                wake_src  <= wake_is_rst ? SRC_RST : SRC_IRQ;
            end
        end
    end

    // Decode the clock and mask controls from the state
    always_comb begin
        osc_en        = (st != ST_HALT);
        periph_clk_en = (st == ST_RUN);
        cpu_clk_en    = (st == ST_RUN);
        imask_clr     = (st != ST_RUN);
    end

    // R2
    act_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_RUN) && halt_req && act_halt_en) |=> (cpu_clk_en && osc_en && !wdg_rst));

    // R3
    wdg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_RUN) && halt_req && !act_halt_en && wdg_en && !wdg_halt_opt)
        |=> (wdg_rst && cpu_clk_en));

    // R4
    enter_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enter |=> (!osc_en && !periph_clk_en && !cpu_clk_en && imask_clr));

    // R7
    settle_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_en) |-> (!cpu_clk_en && !periph_clk_en));

    // R8
    resume_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_clk_en) |-> (vec_fetch != irq_service));

    // R9
    rst_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_HALT) && ext_rst) |=> (wake_src == SRC_RST));
endmodule

// File: tb/halt_pwr_ctrl_tb_top.sv
// Bench: sweeps every interrupt pattern with and without ext_rst, and checks
// the ignore, watchdog, pending-at-entry and settling-length cases.
module halt_pwr_ctrl_tb_top;
    localparam int        CLK_PERIOD = 10;
    localparam int        NIRQ       = 4;
    localparam logic [3:0] MASK      = 4'b0101;
    localparam int        SETTLE     = 64;

    logic clk = 1'b0;
    logic rst_n, halt_req, act_halt_en, wdg_en, wdg_halt_opt, ext_rst;
    logic [NIRQ-1:0] irq_req;
    logic osc_en, periph_clk_en, cpu_clk_en, imask_clr, wdg_rst, vec_fetch, irq_service;
    logic [1:0] wake_src;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    halt_pwr_ctrl #(.NIRQ(NIRQ), .WAKE_MASK(MASK), .SETTLE_CYC(SETTLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .act_halt_en(act_halt_en),
        .wdg_en(wdg_en), .wdg_halt_opt(wdg_halt_opt), .irq_req(irq_req), .ext_rst(ext_rst),
        .osc_en(osc_en), .periph_clk_en(periph_clk_en), .cpu_clk_en(cpu_clk_en),
        .imask_clr(imask_clr), .wdg_rst(wdg_rst), .vec_fetch(vec_fetch),
        .irq_service(irq_service), .wake_src(wake_src)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_clocks_off(input string req);
        chk(!osc_en && !periph_clk_en && !cpu_clk_en && imask_clr, req,
            {osc_en, periph_clk_en, cpu_clk_en, imask_clr}, 4'b0001);
    endtask

    // Enter halt from the running state with no wake input present
    task automatic enter_halt();
        halt_req = 1'b1;
        step();
        halt_req = 1'b0;
        check_clocks_off("R4 enter");
        chk(wake_src == 2'd0, "R10 cleared on entry", wake_src, 0);
    endtask

    // Count the settling window, then check the resume strobe and the status
    task automatic settle_and_resume(input bit by_rst, input string req);
        int n = 0;
        while (!cpu_clk_en && osc_en && n < 300) begin
            n++;
            step();
        end
        chk(n == SETTLE, {req, " R7 settle length"}, n, SETTLE);
        chk(osc_en && periph_clk_en && cpu_clk_en && !imask_clr, "R7 clocks back",
            {osc_en, periph_clk_en, cpu_clk_en, imask_clr}, 4'b1110);
        chk(vec_fetch == by_rst && irq_service == !by_rst, {req, " R8 strobe"},
            {vec_fetch, irq_service}, {by_rst, !by_rst});
        chk(wake_src == (by_rst ? 2'd1 : 2'd2), {req, " R10 source"}, wake_src, by_rst ? 1 : 2);
        step();
        chk(!vec_fetch && !irq_service, "R8 one cycle", {vec_fetch, irq_service}, 0);
        chk(wake_src == (by_rst ? 2'd1 : 2'd2), "R10 held", wake_src, by_rst ? 1 : 2);
    endtask

    initial begin
        rst_n = 1'b0; halt_req = 1'b0; act_halt_en = 1'b0; wdg_en = 1'b0;
        wdg_halt_opt = 1'b0; ext_rst = 1'b0; irq_req = '0;
        @(negedge clk);
        step();
        rst_n = 1'b1;
        step();
        // R1
        chk(osc_en && periph_clk_en && cpu_clk_en && !imask_clr && !wdg_rst &&
            !vec_fetch && !irq_service && wake_src == 2'd0, "R1 reset state",
            {osc_en, periph_clk_en, cpu_clk_en, imask_clr}, 4'b1110);

        // R2: active-halt selected, so the request is ignored
        act_halt_en = 1'b1; halt_req = 1'b1;
        step();
        halt_req = 1'b0;
        chk(cpu_clk_en && osc_en && periph_clk_en && !wdg_rst, "R2 ignored",
            {osc_en, cpu_clk_en, wdg_rst}, 3'b110);
        act_halt_en = 1'b0;

        // R3: watchdog running, option clear
        wdg_en = 1'b1; wdg_halt_opt = 1'b0; halt_req = 1'b1;
        step();
        halt_req = 1'b0;
        chk(wdg_rst && cpu_clk_en && osc_en, "R3 watchdog reset", {wdg_rst, cpu_clk_en}, 2'b11);
        step();
        chk(!wdg_rst && cpu_clk_en, "R3 one cycle", wdg_rst, 0);

        // Sweep of all interrupt patterns and both reset values (R5, R9, R4 with opt=1)
        wdg_halt_opt = 1'b1;
        for (int r = 0; r < 2; r++) begin
            for (int p = 0; p < 16; p++) begin
                bit exp_wake;
                exp_wake = (r != 0) || ((p[3:0] & MASK) != 4'b0);
                enter_halt();
                irq_req = p[3:0]; ext_rst = r[0];
                step();
                irq_req = '0; ext_rst = 1'b0;
                if (exp_wake) begin
                    chk(osc_en && !cpu_clk_en, "R5 wake line", p, r);
                    settle_and_resume(r != 0, (r != 0 && (p & MASK) != 0) ? "R9 prio" : "R5");
                end else begin
                    check_clocks_off("R5 ignored line");
                    step();
                    check_clocks_off("R5 still halted");
                    ext_rst = 1'b1;
                    step();
                    ext_rst = 1'b0;
                    settle_and_resume(1'b1, "R5 recover");
                end
            end
        end

        // R6: wake-capable interrupt pending in the entry cycle
        wdg_en = 1'b0;
        irq_req = 4'b0100; halt_req = 1'b1;
        step();
        halt_req = 1'b0;
        check_clocks_off("R6 first halted cycle");
        step();
        irq_req = '0;
        chk(osc_en && !cpu_clk_en, "R6 immediate wake", osc_en, 1);
        settle_and_resume(1'b0, "R6");

        // R11: two wakes in a row, each with the full window
        for (int k = 0; k < 2; k++) begin
            enter_halt();
            irq_req = 4'b0001;
            step();
            irq_req = '0;
            settle_and_resume(1'b0, "R11");
        end

        done = 1'b1;
    end

    // Watchdog and summary
    initial begin
        int cyc = 0;
        while (!done && cyc < 50000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule